// File: doc/BRIEF.md
# Cascaded Nibble Magnitude Comparator

This block compares two unsigned operands and raises exactly one of three flags: the first operand is larger, the two are equal, or the first operand is smaller. It is purely combinational. The operands are cut into 4-bit nibbles, and each nibble has its own slice. A slice works out how its two nibbles relate and folds that into a three-wire relation (greater, equal, less) handed up from the slice below it. The merged relation then passes on to the slice above.

The chain runs from the least significant nibble to the most significant one. The bottom slice is fed a fixed "equal so far" relation. The three result flags are the relation that leaves the top slice. The number of slices is a parameter with a default of four, which gives a 16-bit compare. The block suits designs that need a ripple-style compare with a visible per-nibble structure rather than one wide relational operator.

Top module: `magcmp_chain`

## Requirements
- R1: Two nibbles count as locally equal only when every one of their four bit positions holds the same value. A single differing bit at any position 0..3 makes them unequal.
- R2: A slice passes "greater" upward when its own nibble of the first operand is larger, or when its nibbles are equal and the relation from below is "greater".
- R3: A slice passes "equal" upward only when its nibbles are equal and the relation from below is "equal".
- R4: A slice passes "less" upward when its own nibble of the first operand is smaller, or when its nibbles are equal and the relation from below is "less".
- R5: Bits [3:0] feed the bottom slice and the top nibble (bits [15:12] by default) feeds the top slice. A difference in a higher nibble overrides any difference in a lower nibble.
- R6: The bottom slice receives greater=0, equal=1, less=0, so identical operands (including all-zero and all-one) report equal.
- R7: Exactly one of the three output flags is high for every operand pair.
- R8: The flags match an unsigned compare of the full operands: `gt_o` for A>B, `eq_o` for A=B, `lt_o` for A<B.
- R9: The flags depend on the operands combinationally and are valid in the same cycle the operands are applied, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 4*N_SLICES (16) | First unsigned operand (A) |
| opb_i | input | 4*N_SLICES (16) | Second unsigned operand (B) |
| gt_o | output | 1 | High when A > B |
| eq_o | output | 1 | High when A = B |
| lt_o | output | 1 | High when A < B |

## Verification
There are no registers on the path, so each flag is due zero cycles after a new operand pair arrives, once the ripple through the slices has settled. The bench drives the operands just after a rising clock edge and samples the three flags at the following falling edge, half a period later, with no edge counted in between. The expected relation comes from a plain whole-operand unsigned compare written in the bench. The slice-level rules are reached through operand pairs whose upper nibbles tie, so that a lower nibble has to decide the result.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;

  localparam int NIB_W = 4;

  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } rel_t;

  localparam rel_t REL_TIE = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};

  // Nibble equality: every bit position must agree (XNOR reduced by AND).
  function automatic logic nib_same(input logic [NIB_W-1:0] a,
                                    input logic [NIB_W-1:0] b);
    logic r;
    r = 1'b1;
    for (int i = 0; i < NIB_W; i++) begin
      r = r & ~(a[i] ^ b[i]);
    end
    return r;
  endfunction

  // Nibble greater: scan from the top bit down; the first disagreeing
  // position decides, and A wins if it holds the 1 there.
  function automatic logic nib_above(input logic [NIB_W-1:0] a,
                                     input logic [NIB_W-1:0] b);
    logic r;
    logic hit;
    r   = 1'b0;
    hit = 1'b0;
    for (int i = NIB_W - 1; i >= 0; i--) begin
      if (!hit && (a[i] != b[i])) begin
        r   = a[i];
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  // Fold a local nibble relation with the relation arriving from below.
  function automatic rel_t rel_merge(input rel_t here, input rel_t below);
    rel_t r;
    r.gt = here.gt | (here.eq & below.gt);
    r.eq = here.eq & below.eq;
    r.lt = here.lt | (here.eq & below.lt);
    return r;
  endfunction

endpackage

// File: rtl/magcmp_nibble.sv
module magcmp_nibble
  import magcmp_pkg::*;
(
  input  logic [NIB_W-1:0] a_i,
  input  logic [NIB_W-1:0] b_i,
  output rel_t             rel_o
);

  logic same_w;
  logic above_w;
  logic below_w;

  assign same_w  = nib_same(a_i, b_i);
  assign above_w = nib_above(a_i, b_i);
  assign below_w = ~same_w & ~above_w;

  assign rel_o = '{gt: above_w, eq: same_w, lt: below_w};

  always_comb begin
    // R1: equality means no bit position differs
    a_r1_same_exact: assert (same_w == (a_i == b_i))
      else $error("R1 nibble equality wrong a=%h b=%h", a_i, b_i);
    a_r1_local_onehot: assert ($onehot({above_w, same_w, below_w}))
      else $error("R1 local relation not one-hot");
  end

endmodule

// File: rtl/magcmp_slice.sv
module magcmp_slice
  import magcmp_pkg::*;
(
  input  logic [NIB_W-1:0] a_i,
  input  logic [NIB_W-1:0] b_i,
  input  rel_t             cin_i,
  output rel_t             cout_o
);

  rel_t loc_rel;
  logic pass_up;

  magcmp_nibble u_nib (
    .a_i   (a_i),
    .b_i   (b_i),
    .rel_o (loc_rel)
  );

  assign pass_up = loc_rel.eq;
  assign cout_o  = rel_merge(loc_rel, cin_i);

  always_comb begin
    // R2, R3, R4: a tied nibble forwards the lower relation unchanged
    if (pass_up) begin
      a_r3_tie_forwards: assert (cout_o == cin_i)
        else $error("R3 tied slice did not forward relation");
    end
    // R2: a local win forces greater
    if (loc_rel.gt) begin
      a_r2_local_wins: assert (cout_o.gt && !cout_o.eq && !cout_o.lt)
        else $error("R2 local greater not forwarded");
    end
    // R4: a local loss forces less
    if (loc_rel.lt) begin
      a_r4_local_loses: assert (cout_o.lt && !cout_o.eq && !cout_o.gt)
        else $error("R4 local less not forwarded");
    end
  end

endmodule

// File: rtl/magcmp_chain.sv
module magcmp_chain
  import magcmp_pkg::*;
#(
  parameter int N_SLICES = 4,
  localparam int W = NIB_W * N_SLICES
) (
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic         gt_o,
  output logic         eq_o,
  output logic         lt_o
);

  rel_t link [N_SLICES+1];

  // R6: the bottom of the chain starts from "equal so far"
  assign link[0] = REL_TIE;

  for (genvar s = 0; s < N_SLICES; s++) begin : g_slice
    magcmp_slice u_slice (
      .a_i    (opa_i[s*NIB_W +: NIB_W]),
      .b_i    (opb_i[s*NIB_W +: NIB_W]),
      .cin_i  (link[s]),
      .cout_o (link[s+1])
    );
  end

  assign gt_o = link[N_SLICES].gt;
  assign eq_o = link[N_SLICES].eq;
  assign lt_o = link[N_SLICES].lt;

  always_comb begin
    a_r7_one_flag: assert ($onehot({gt_o, eq_o, lt_o}))
      else $error("R7 flags not one-hot");
    a_r8_matches_compare: assert ((gt_o == (opa_i > opb_i)) &&
                                  (lt_o == (opa_i < opb_i)))
      else $error("R8 flags disagree with unsigned compare");
    a_r6_tie_gives_eq: assert ((opa_i != opb_i) || eq_o)
      else $error("R6 identical operands not equal");
  end

endmodule

// File: tb/tb_magcmp_chain.sv
`timescale 1ns/1ps
module tb_magcmp_chain;

  localparam int NS = 4;
  localparam int W  = 4 * NS;

  logic         clk;
  logic         rst;
  logic [W-1:0] opa;
  logic [W-1:0] opb;
  logic         gt_w, eq_w, lt_w;
  int           n_checks;
  int           n_fail;
  bit           done;

  magcmp_chain #(.N_SLICES(NS)) dut (
    .opa_i (opa),
    .opb_i (opb),
    .gt_o  (gt_w),
    .eq_o  (eq_w),
    .lt_o  (lt_w)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  // Drive after a rising edge, sample at the next falling edge (R9: 0 cycles).
  task automatic apply_check(input logic [W-1:0] a, input logic [W-1:0] b,
                             input string req);
    logic [2:0] exp_f;
    logic [2:0] got_f;
    @(posedge clk);
    #0.5;
    opa = a;
    opb = b;
    @(negedge clk);
    exp_f = (a > b) ? 3'b100 : ((a == b) ? 3'b010 : 3'b001);
    got_f = {gt_w, eq_w, lt_w};
    n_checks++;
    if (got_f !== exp_f) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h got gt/eq/lt=%b expected=%b", req, a, b, got_f, exp_f);
    end
    n_checks++;
    if ($countones(got_f) != 1) begin
      n_fail++;
      $display("FAIL R7 a=%h b=%h got gt/eq/lt=%b expected one-hot", a, b, got_f);
    end
  endtask

  task automatic t_reset_state;  // R6, R9
    apply_check('0, '0, "R6 reset state zero operands");
  endtask

  task automatic t_extremes;  // R6, R8
    apply_check('1, '1, "R6 all ones equal");
    apply_check('1, '0, "R8 all ones vs zero");
    apply_check('0, '1, "R8 zero vs all ones");
    apply_check(16'h5A3C, 16'h5A3C, "R6 equal pattern");
  endtask

  task automatic t_single_bits;  // R1: a lone differing bit in every position
    for (int i = 0; i < W; i++) begin
      apply_check(W'(1) << i, '0, "R1 single bit set in A");
      apply_check(16'hFFFF, 16'hFFFF ^ (W'(1) << i), "R1 single bit clear in B");
    end
  endtask

  task automatic t_low_decides;  // R2, R4: upper nibbles tie, bottom decides
    apply_check(16'h1231, 16'h1230, "R2 lsb only greater");
    apply_check(16'h1230, 16'h1231, "R4 lsb only less");
    apply_check(16'hABC9, 16'hABC3, "R2 bottom nibble greater");
    apply_check(16'hABC3, 16'hABC9, "R4 bottom nibble less");
    apply_check(16'h77F7, 16'h7707, "R3 tie then greater mid");
  endtask

  task automatic t_order;  // R5: higher nibble overrides lower
    apply_check(16'h8000, 16'h0000, "R5 msb only greater");
    apply_check(16'h0000, 16'h8000, "R5 msb only less");
    apply_check(16'h1000, 16'h0FFF, "R5 top wins over lower");
    apply_check(16'h0FFF, 16'h1000, "R5 top loses over lower");
    apply_check(16'h2F00, 16'h30FF, "R5 nibble order");
  endtask

  task automatic t_random;  // R8, R7
    for (int k = 0; k < 300; k++) begin
      logic [W-1:0] a;
      logic [W-1:0] b;
      a = W'($urandom);
      b = (k % 4 == 0) ? a : W'($urandom);
      if (k % 4 == 1) b = a ^ (W'(1) << (k % W));
      apply_check(a, b, "R8 random");
    end
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    done     = 1'b0;
    rst      = 1'b1;
    opa      = '0;
    opb      = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_extremes();
    t_single_bits();
    t_low_decides();
    t_order();
    t_random();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired got running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule